// File: doc/BRIEF.md
# Retimer Channel Adaptation and Lock Supervisor

This block is the control brain of one retimer channel. It decides when the channel's equalizer should be tuned, when the recovered clock may be reported as locked, and when that lock has been lost. The analog equalizer tuner, the clock-and-data-recovery loop and the eye-opening measurement all sit outside it. The block talks to them through plain signals: a start/done handshake toward the tuner, a raw phase-lock level from the recovery loop, measured horizontal and vertical eye openings with a valid strobe, and a frequency-drift flag derived from the reference clock.

Lock is granted only when the recovery loop reports phase lock and a valid eye sample shows both openings strictly above programmable minimums. While locked, the block keeps watching for three things: frequency drift, loss of phase lock, and (when enabled) a poor eye sample. Any one of them drops the lock and sets a sticky interrupt. The channel then goes back to acquisition on its own, and runs a fresh equalizer adaptation first when the mode field asks for one. A host can also force an adaptation by raising a trigger bit and then lowering it again.

Top module: `lock_supervisor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lockStatus`, `lossIrq` and `tunerStart` are all 0.
- R2: With `cfgMode` = 2'b01, the block enters adaptation after reset and after every loss of lock. In adaptation, `tunerStart` stays high until the cycle in which `tunerDone` is sampled high, and then acquisition begins. With `cfgMode` = 2'b00, 2'b10 or 2'b11, no automatic adaptation happens and acquisition follows directly.
- R3: In acquisition, `lockStatus` rises one cycle after a clock edge at which all of the following are sampled: `cdrLocked` = 1, `eyeValid` = 1, `freqDrift` = 0, and both openings above their minimums.
- R4: An opening counts as sufficient only when it is strictly greater than its 8-bit unsigned minimum. An opening equal to its minimum does not grant lock.
- R5: While locked with `cfgEyeCheckEn` = 1, a valid sample whose horizontal or vertical opening is not above its minimum drops `lockStatus` on the next cycle and sets `lossIrq`.
- R6: While locked with `cfgEyeCheckEn` = 0, eye samples are ignored and `lockStatus` stays high.
- R7: While locked, `freqDrift` = 1 or `cdrLocked` = 0 drops `lockStatus` on the next cycle and sets `lossIrq`, with no eye sample needed. These lock-loss causes take priority over a trigger event in the same cycle.
- R8: `lossIrq` is sticky. It clears only on a cycle in which `irqClear` is high and no new loss occurs. A new loss wins over a clear in the same cycle.
- R9: The lost state lasts exactly one cycle. After it, the block enters adaptation (mode 2'b01) or acquisition (other modes).
- R10: A trigger event is a cycle in which `adaptTrig` is 0 after having been 1 on the previous cycle. Holding `adaptTrig` high does nothing. An event starts an adaptation from idle, acquisition, lock or the lost state, in any mode.
- R11: A trigger event that arrives during adaptation is ignored. `tunerStart` stays high until `tunerDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Adaptation mode (01 adapt, others none) |
| cfgEyeCheckEn | input | 1 | Enables eye checking while locked |
| cfgHorizMin | input | 8 | Horizontal opening minimum |
| cfgVertMin | input | 8 | Vertical opening minimum |
| adaptTrig | input | 1 | Host adaptation trigger bit |
| eyeHoriz | input | 8 | Measured horizontal opening |
| eyeVert | input | 8 | Measured vertical opening |
| eyeValid | input | 1 | Eye measurement valid strobe |
| cdrLocked | input | 1 | Raw phase-lock level from the recovery loop |
| freqDrift | input | 1 | Reference-based frequency drift flag |
| irqClear | input | 1 | Write-one-to-clear pulse for the interrupt |
| tunerDone | input | 1 | Equalizer tuner completion |
| tunerStart | output | 1 | Equalizer tuner start request |
| lockStatus | output | 1 | Lock status level |
| lossIrq | output | 1 | Sticky loss-of-lock interrupt |

## Verification
Every output is registered exactly once, so each output reacts one cycle after the edge at which its cause was sampled. A trigger event needs the previous cycle's trigger level, so an adaptation starts on the cycle after the falling trigger edge is sampled. The bench drives inputs on the falling clock edge and steps a behavioural model at the next falling edge, using the inputs that were held across the rising edge between them. It then compares all three outputs to that model on every cycle, so a result arriving one cycle early or late shows up as a miscompare.

// File: rtl/lsup_pkg.sv
package lsup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADAPT,
    ST_ACQUIRE,
    ST_LOCKED,
    ST_LOST
  } supState_t;

  typedef struct packed {
    logic raiseIrq;
    logic lockLost;
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_ADAPT = 2'b01;
endpackage

// File: rtl/lsup_datapath.sv
module lsup_datapath
  import lsup_pkg::*;
#(
  parameter int EYE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EYE_W-1:0] eyeHoriz,
  input  logic [EYE_W-1:0] eyeVert,
  input  logic [EYE_W-1:0] horizMin,
  input  logic [EYE_W-1:0] vertMin,
  input  logic             adaptTrig,
  input  logic             irqClear,
  input  ctrlStrobe_t      strobe,
  output logic             eyeOk,
  output logic             trigEvent,
  output logic             lossIrq
);
  localparam int AXES = 2;

  logic [AXES-1:0][EYE_W-1:0] opening;
  logic [AXES-1:0][EYE_W-1:0] minimum;
  logic [AXES-1:0]            axisOk;
  logic                       trigQ;

  assign opening = {eyeVert, eyeHoriz};
  assign minimum = {vertMin, horizMin};

  // Strict comparison per axis; equality is not enough.
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    assign axisOk[a] = opening[a] > minimum[a];
  end

  assign eyeOk = &axisOk;

  // Set-then-clear detection on the host trigger.
  always_ff @(posedge clk) begin
    if (!rstN) trigQ <= 1'b0;
    else       trigQ <= adaptTrig;
  end
  assign trigEvent = trigQ & ~adaptTrig;

  // Sticky interrupt; a new loss wins over a clear.
  always_ff @(posedge clk) begin
    if (!rstN)                lossIrq <= 1'b0;
    else if (strobe.raiseIrq) lossIrq <= 1'b1;
    else if (irqClear)        lossIrq <= 1'b0;
  end

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lossIrq && !irqClear) |=> lossIrq);

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossIrq) |-> $past(strobe.lockLost));
endmodule

// File: rtl/lsup_ctrl.sv
module lsup_ctrl
  import lsup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        cfgEyeCheckEn,
  input  logic        eyeValid,
  input  logic        eyeOk,
  input  logic        cdrLocked,
  input  logic        freqDrift,
  input  logic        trigEvent,
  input  logic        tunerDone,
  output logic        tunerStart,
  output logic        lockStatus,
  output ctrlStrobe_t strobe
);
  supState_t state, stateNext;
  logic      adaptOn;
  logic      lossNow;
  logic      grantNow;

  assign adaptOn  = (cfgMode == MODE_ADAPT);
  assign grantNow = cdrLocked && !freqDrift && eyeValid && eyeOk;
  assign lossNow  = freqDrift || !cdrLocked || (cfgEyeCheckEn && eyeValid && !eyeOk);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (trigEvent || adaptOn) stateNext = ST_ADAPT;
        else                      stateNext = ST_ACQUIRE;
      end
      ST_ADAPT: begin
        if (tunerDone) stateNext = ST_ACQUIRE;
      end
      ST_ACQUIRE: begin
        if (trigEvent)     stateNext = ST_ADAPT;
        else if (grantNow) stateNext = ST_LOCKED;
      end
      ST_LOCKED: begin
        if (lossNow)        stateNext = ST_LOST;
        else if (trigEvent) stateNext = ST_ADAPT;
      end
      ST_LOST: begin
        if (trigEvent || adaptOn) stateNext = ST_ADAPT;
        else                      stateNext = ST_ACQUIRE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.lockLost = (state == ST_LOCKED) && lossNow;
  assign strobe.raiseIrq = strobe.lockLost;
  assign tunerStart      = (state == ST_ADAPT);
  assign lockStatus      = (state == ST_LOCKED);

  // R3
  lock_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatus) |-> $past(cdrLocked && eyeValid && eyeOk && !freqDrift));

  // R7
  drift_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockStatus && freqDrift) |=> !lockStatus);

  // R6
  unchecked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockStatus && !cfgEyeCheckEn && cdrLocked && !freqDrift && !trigEvent) |=> lockStatus);

  // R9
  lost_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOST) |=> (state != ST_LOST));

  // R11
  start_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tunerStart && !tunerDone) |=> tunerStart);
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lsup_pkg::*;
#(
  parameter int EYE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgEyeCheckEn,
  input  logic [EYE_W-1:0] cfgHorizMin,
  input  logic [EYE_W-1:0] cfgVertMin,
  input  logic             adaptTrig,
  input  logic [EYE_W-1:0] eyeHoriz,
  input  logic [EYE_W-1:0] eyeVert,
  input  logic             eyeValid,
  input  logic             cdrLocked,
  input  logic             freqDrift,
  input  logic             irqClear,
  input  logic             tunerDone,
  output logic             tunerStart,
  output logic             lockStatus,
  output logic             lossIrq
);
  ctrlStrobe_t strobe;
  logic        eyeOk;
  logic        trigEvent;

  lsup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgMode      (cfgMode),
    .cfgEyeCheckEn(cfgEyeCheckEn),
    .eyeValid     (eyeValid),
    .eyeOk        (eyeOk),
    .cdrLocked    (cdrLocked),
    .freqDrift    (freqDrift),
    .trigEvent    (trigEvent),
    .tunerDone    (tunerDone),
    .tunerStart   (tunerStart),
    .lockStatus   (lockStatus),
    .strobe       (strobe)
  );

  lsup_datapath #(.EYE_W(EYE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .eyeHoriz (eyeHoriz),
    .eyeVert  (eyeVert),
    .horizMin (cfgHorizMin),
    .vertMin  (cfgVertMin),
    .adaptTrig(adaptTrig),
    .irqClear (irqClear),
    .strobe   (strobe),
    .eyeOk    (eyeOk),
    .trigEvent(trigEvent),
    .lossIrq  (lossIrq)
  );
endmodule

// File: tb/tb_lock_supervisor.sv
module tb_lock_supervisor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgMode = 2'b01;
  logic       cfgEyeCheckEn = 1'b1;
  logic [7:0] cfgHorizMin = 8'h40;
  logic [7:0] cfgVertMin = 8'h30;
  logic       adaptTrig = 1'b0;
  logic [7:0] eyeHoriz = 8'h00;
  logic [7:0] eyeVert = 8'h00;
  logic       eyeValid = 1'b0;
  logic       cdrLocked = 1'b0;
  logic       freqDrift = 1'b0;
  logic       irqClear = 1'b0;
  logic       tunerDone = 1'b0;
  logic       tunerStart, lockStatus, lossIrq;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // model state: 0 idle, 1 adapt, 2 acquire, 3 locked, 4 lost
  int  mState = 0;
  bit  mIrq = 0;
  bit  mTrigPrev = 0;

  always #5 clk = ~clk;

  lock_supervisor dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgEyeCheckEn(cfgEyeCheckEn),
    .cfgHorizMin(cfgHorizMin), .cfgVertMin(cfgVertMin), .adaptTrig(adaptTrig),
    .eyeHoriz(eyeHoriz), .eyeVert(eyeVert), .eyeValid(eyeValid),
    .cdrLocked(cdrLocked), .freqDrift(freqDrift), .irqClear(irqClear),
    .tunerDone(tunerDone), .tunerStart(tunerStart), .lockStatus(lockStatus),
    .lossIrq(lossIrq)
  );

  function automatic void modelStep();
    bit trig, good, loss, raise;
    int nxt;
    if (!rstN) begin
      mState = 0; mIrq = 0; mTrigPrev = 0;
      return;
    end
    trig  = mTrigPrev && !adaptTrig;
    good  = (eyeHoriz > cfgHorizMin) && (eyeVert > cfgVertMin);
    loss  = freqDrift || !cdrLocked || (cfgEyeCheckEn && eyeValid && !good);
    raise = 0;
    nxt   = mState;
    if (mState == 0 || mState == 4)
      nxt = (trig || cfgMode == 2'b01) ? 1 : 2;
    else if (mState == 1) begin
      if (tunerDone) nxt = 2;
    end else if (mState == 2) begin
      if (trig) nxt = 1;
      else if (cdrLocked && !freqDrift && eyeValid && good) nxt = 3;
    end else begin
      if (loss) begin nxt = 4; raise = 1; end
      else if (trig) nxt = 1;
    end
    if (raise) mIrq = 1;
    else if (irqClear) mIrq = 0;
    mTrigPrev = adaptTrig;
    mState = nxt;
  endfunction

  task automatic cmp(input bit act, input bit exp, input string req, input string name);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, name, cycles, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      modelStep();
      cmp(tunerStart, mState == 1, "R2", "tunerStart");
      cmp(lockStatus, mState == 3, "R3", "lockStatus");
      cmp(lossIrq,    mIrq,        "R8", "lossIrq");
    end
  endtask

  task automatic goodEye();
    eyeHoriz = 8'h50; eyeVert = 8'h48; eyeValid = 1'b1; cdrLocked = 1'b1;
  endtask

  task automatic finishDone();
    tunerDone = 1'b1; step(1); tunerDone = 1'b0;
  endtask

  initial begin
    // R1: reset state, during reset and on the first cycle after it
    step(3);
    rstN = 1'b1;
    step(1);
    // R2: mode 01 holds tunerStart until done
    step(4);
    finishDone();
    // R4: openings equal to minimum do not lock
    eyeHoriz = 8'h40; eyeVert = 8'h31; eyeValid = 1'b1; cdrLocked = 1'b1;
    step(3);
    eyeHoriz = 8'h50; eyeVert = 8'h30;
    step(3);
    // R3: both strictly above -> lock
    goodEye();
    step(4);
    // R5: horizontal opening drops -> loss, irq, then re-adapt (R9)
    eyeHoriz = 8'h20;
    step(2);
    eyeHoriz = 8'h50;
    step(2);
    finishDone();
    step(3);
    // R5: vertical opening drops
    eyeVert = 8'h10;
    step(1);
    eyeVert = 8'h48;
    step(2);
    finishDone();
    step(2);
    // R8: clear the interrupt; then a clear together with a new loss
    irqClear = 1'b1; step(1); irqClear = 1'b0;
    step(2);
    freqDrift = 1'b1; irqClear = 1'b1; step(1); irqClear = 1'b0;
    // R7: drift held in acquisition blocks lock
    step(3);
    finishDone();
    step(3);
    freqDrift = 1'b0;
    step(3);
    // R6: eye check disabled -> bad eye ignored
    cfgEyeCheckEn = 1'b0;
    eyeHoriz = 8'h05; eyeVert = 8'h05;
    step(5);
    cfgEyeCheckEn = 1'b1;
    goodEye();
    step(2);
    // R7: CDR lock drop ends lock
    irqClear = 1'b1; step(1); irqClear = 1'b0;
    cdrLocked = 1'b0;
    step(3);
    // R2 / R9: mode 00 goes straight to acquisition
    cfgMode = 2'b00;
    step(2);
    finishDone();
    cdrLocked = 1'b1;
    step(3);
    eyeVert = 8'h00; step(1); eyeVert = 8'h48;
    step(4);
    // mode 11 behaves like 00
    cfgMode = 2'b11;
    freqDrift = 1'b1; step(1); freqDrift = 1'b0;
    step(4);
    // R10: holding the trigger high does nothing; release starts adaptation
    adaptTrig = 1'b1;
    step(5);
    adaptTrig = 1'b0;
    step(3);
    // R11: trigger during adaptation is ignored
    adaptTrig = 1'b1; step(1); adaptTrig = 1'b0;
    step(3);
    finishDone();
    step(3);
    // R10: trigger from acquisition, mode 10
    cfgMode = 2'b10;
    eyeValid = 1'b0;
    cdrLocked = 1'b0; step(3);
    adaptTrig = 1'b1; step(1); adaptTrig = 1'b0;
    step(2);
    finishDone();
    goodEye();
    step(3);
    // R7: drift plus trigger in the same cycle: loss wins
    adaptTrig = 1'b1; step(1);
    adaptTrig = 1'b0; freqDrift = 1'b1; step(1); freqDrift = 1'b0;
    step(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule